// File: doc/BRIEF.md
# DMA Line-Chunking Request Sequencer

This block takes one DMA transfer at a time and turns it into a chain of memory requests, none of which crosses a cache-line boundary. A transfer is described by a start byte address, a byte count, a direction (load or store) and, for stores, a byte buffer. The first request starts at the transfer's offset inside its line and stops at the end of that line or at the end of the transfer, whichever comes first. Every later request starts on a line boundary and carries up to one full line.

Only one request is in flight at a time. After a request is handed over on the valid/ready request port, the block waits for a response before it sends the next one. A response to a load carries a full line of data, and the block copies the bytes of interest into a local read buffer at the matching transfer position. A response to a store is a plain acknowledgement. When the last byte is accounted for, the block pulses a completion strobe with the tag it gave the transfer on acceptance.

The controller has four states. `S_IDLE` waits for a start. `S_ISSUE` presents a chunk. `S_WAIT` waits for the response. `S_COMPLETE` is a one-cycle completion pulse. The transitions are: IDLE→ISSUE on an accepted start; ISSUE→WAIT on the request handshake; WAIT→ISSUE on a response while bytes remain; WAIT→COMPLETE on a response once every byte has been issued; COMPLETE→IDLE unconditionally.

Top module: `dma_line_seq`

## Requirements
- R1: A start pulse seen while the block is busy (any state other than idle) is rejected. `start_err` pulses in the next cycle, and the transfer in progress goes on unchanged.
- R2: The first chunk has offset = start address mod LINE_BYTES. Its length is the transfer length if offset + length ≤ LINE_BYTES, and LINE_BYTES − offset otherwise.
- R3: Every chunk after the first has offset 0 and line address (start address + bytes completed) / LINE_BYTES.
- R4: Every chunk after the first has length min(remaining bytes, LINE_BYTES).
- R5: `req_valid` and the chunk fields stay steady until `req_ready`. No request is presented between the handshake and the next response.
- R6: The response to the last chunk is followed, in the next cycle, by a one-cycle `done_valid` pulse carrying `done_id`. `busy` is low in the cycle after that pulse.
- R7: For a load, the response's line bytes from the chunk offset onward, for the chunk length, are written to read buffer byte positions starting at the bytes already completed. `rd_buf` byte k sits at bits [8k+7:8k].
- R8: For a store, `req_data` line byte i (bits [8i+7:8i]) for offset ≤ i < offset + length holds buffer byte (completed + i − offset). Every other line byte is zero. `req_write` is 1 for stores and 0 for loads.
- R9: `start_kind` 0 is a load and 1 is a store. Codes 2–7 (fetch, locked and read-modify-write kinds) are rejected with `start_err`. So is a length of 0 or a length above MAX_LEN.
- R10: Each accepted transfer is answered in the next cycle with a `start_accept` pulse and `start_id`. IDs count up from 0 after reset, modulo 2^ID_W.
- R11: A response that arrives outside the waiting state is ignored. Response data has no effect during a store transfer.
- R12: After reset, `busy`, `req_valid`, `done_valid`, `start_accept` and `start_err` are 0, and `rd_buf` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | One-cycle start pulse |
| start_kind | input | 3 | Request kind; 0 load, 1 store, others illegal |
| start_addr | input | ADDR_W | Start byte address |
| start_len | input | LEN_W | Transfer length in bytes |
| start_wdata | input | MAX_LEN*8 | Store buffer, byte k at bits [8k+7:8k] |
| start_accept | output | 1 | Transfer accepted (pulse) |
| start_err | output | 1 | Start rejected (pulse) |
| start_id | output | ID_W | Tag of the accepted transfer |
| busy | output | 1 | A transfer is in progress |
| req_valid | output | 1 | Chunk request valid |
| req_ready | input | 1 | Request queue takes the chunk |
| req_line_addr | output | ADDR_W-OFF_W | Line address of the chunk |
| req_offset | output | OFF_W | Byte offset inside the line |
| req_len | output | OFF_W+1 | Chunk length in bytes |
| req_write | output | 1 | 1 for store chunks |
| req_data | output | LINE_BYTES*8 | Store data in line byte positions |
| rsp_valid | input | 1 | Response strobe |
| rsp_has_data | input | 1 | Response carries load data |
| rsp_data | input | LINE_BYTES*8 | Returned line |
| done_valid | output | 1 | Transfer complete (pulse) |
| done_id | output | ID_W | Tag of the completed transfer |
| rd_buf | output | MAX_LEN*8 | Read buffer, byte k at bits [8k+7:8k] |

## Verification
Two things can meet in one cycle: the completion pulse of a transfer and a new start pulse. Because the controller is still in the completing state in that cycle, the start must be refused with `start_err`. The bench sets this up by driving a start exactly in the cycle it sees `done_valid`. It then checks that the start is rejected, that the ID counter does not move, and that the block is idle afterwards. A second overlap is a start or a stray response arriving while a chunk is pending or awaited. The bench injects both mid-transfer and checks that the chunk sequence and the read buffer come out exactly as the reference model predicts.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_ISSUE    = 2'd1,
        S_WAIT     = 2'd2,
        S_COMPLETE = 2'd3
    } seq_state_t;

    typedef enum logic [2:0] {
        KIND_LOAD    = 3'd0,
        KIND_STORE   = 3'd1,
        KIND_FETCH   = 3'd2,
        KIND_LOCK_RD = 3'd3,
        KIND_LOCK_WR = 3'd4,
        KIND_RMW_RD  = 3'd5,
        KIND_RMW_WR  = 3'd6,
        KIND_NONE    = 3'd7
    } req_kind_t;

    function automatic logic kind_is_legal(input logic [2:0] k);
        return (k == KIND_LOAD) || (k == KIND_STORE);
    endfunction

endpackage

// File: rtl/dls_chunk_calc.sv
module dls_chunk_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_LEN    = 256,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input  logic [ADDR_W-1:0]       base_addr,
    input  logic [LEN_W-1:0]        total_len,
    input  logic [LEN_W-1:0]        done_bytes,
    output logic [ADDR_W-OFF_W-1:0] line_addr,
    output logic [OFF_W-1:0]        line_off,
    output logic [OFF_W:0]          chunk_len
);
    logic [ADDR_W-1:0] cursor;
    logic [OFF_W:0]    room;
    logic [LEN_W-1:0]  remain;

    always_comb begin
        cursor    = base_addr + ADDR_W'(done_bytes);
        line_addr = cursor[ADDR_W-1:OFF_W];
        line_off  = (done_bytes == '0) ? base_addr[OFF_W-1:0] : '0;
        room      = (OFF_W+1)'(LINE_BYTES) - {1'b0, line_off};
        remain    = total_len - done_bytes;
        if (int'(remain) < int'(room)) begin
            chunk_len = (OFF_W+1)'(remain);
        end else begin
            chunk_len = room;
        end
    end

endmodule

// File: rtl/dls_wr_lane.sv
module dls_wr_lane #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_LEN    = 256,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1),
    localparam int IDX_W     = $clog2(MAX_LEN)
) (
    input  logic                    clk,
    input  logic                    load,
    input  logic [MAX_LEN*8-1:0]    wdata_in,
    input  logic [LEN_W-1:0]        done_bytes,
    input  logic [OFF_W-1:0]        off,
    input  logic [OFF_W:0]          clen,
    output logic [LINE_BYTES*8-1:0] line_data
);
    logic [7:0] wmem [MAX_LEN];

    always_ff @(posedge clk) begin
        if (load) begin
            for (int k = 0; k < MAX_LEN; k++) begin
                wmem[k] <= wdata_in[k*8 +: 8];
            end
        end
    end

    always_comb begin
        int src;
        line_data = '0;
        for (int i = 0; i < LINE_BYTES; i++) begin
            src = int'(done_bytes) + i - int'(off);
            if (i >= int'(off) && i < int'(off) + int'(clen) && src < MAX_LEN) begin
                line_data[i*8 +: 8] = wmem[IDX_W'(src)];
            end
        end
    end

endmodule

// File: rtl/dls_rd_store.sv
module dls_rd_store #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_LEN    = 256,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1),
    localparam int IDX_W     = $clog2(MAX_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [LINE_BYTES*8-1:0] line_in,
    input  logic [LEN_W-1:0]        done_bytes,
    input  logic [OFF_W-1:0]        off,
    input  logic [OFF_W:0]          cnt,
    output logic [MAX_LEN*8-1:0]    buf_out
);
    logic [7:0] rmem [MAX_LEN];
    logic [7:0] lbyte [LINE_BYTES];

    genvar g;
    generate
        for (g = 0; g < LINE_BYTES; g++) begin : g_split
            assign lbyte[g] = line_in[g*8 +: 8];
        end
        for (g = 0; g < MAX_LEN; g++) begin : g_join
            assign buf_out[g*8 +: 8] = rmem[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < MAX_LEN; k++) begin
                rmem[k] <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < LINE_BYTES; i++) begin
                if (i >= int'(off) && i < int'(off) + int'(cnt) &&
                    int'(done_bytes) + i - int'(off) < MAX_LEN) begin
                    rmem[IDX_W'(int'(done_bytes) + i - int'(off))] <= lbyte[i];
                end
            end
        end
    end

endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
    import dls_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_LEN    = 256,
    parameter int ID_W       = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int BUF_W     = MAX_LEN * 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_valid,
    input  logic [2:0]              start_kind,
    input  logic [ADDR_W-1:0]       start_addr,
    input  logic [LEN_W-1:0]        start_len,
    input  logic [BUF_W-1:0]        start_wdata,
    output logic                    start_accept,
    output logic                    start_err,
    output logic [ID_W-1:0]         start_id,
    output logic                    busy,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [ADDR_W-OFF_W-1:0] req_line_addr,
    output logic [OFF_W-1:0]        req_offset,
    output logic [OFF_W:0]          req_len,
    output logic                    req_write,
    output logic [LINE_W-1:0]       req_data,
    input  logic                    rsp_valid,
    input  logic                    rsp_has_data,
    input  logic [LINE_W-1:0]       rsp_data,
    output logic                    done_valid,
    output logic [ID_W-1:0]         done_id,
    output logic [BUF_W-1:0]        rd_buf
);
    seq_state_t        state, state_nx;
    logic [ADDR_W-1:0] xfer_addr;
    logic [LEN_W-1:0]  xfer_len;
    logic              xfer_write;
    logic [ID_W-1:0]   xfer_id;
    logic [ID_W-1:0]   id_ctr;
    logic [LEN_W-1:0]  issued;
    logic [LEN_W-1:0]  completed;

    logic              len_ok;
    logic              accept;
    logic              handshake;
    logic              rsp_take;
    logic              rd_we;
    logic [OFF_W:0]    rd_cnt;

    logic [ADDR_W-OFF_W-1:0] c_line;
    logic [OFF_W-1:0]        c_off;
    logic [OFF_W:0]          c_len;

    // start qualification
    always_comb begin
        len_ok    = (start_len != '0) && (int'(start_len) <= MAX_LEN);
        accept    = start_valid && (state == S_IDLE) && kind_is_legal(start_kind) && len_ok;
        handshake = (state == S_ISSUE) && req_ready;
        rsp_take  = (state == S_WAIT) && rsp_valid;
        rd_we     = rsp_take && !xfer_write && rsp_has_data;
        rd_cnt    = (OFF_W+1)'(issued - completed);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (accept) state_nx = S_ISSUE;
            S_ISSUE:    if (req_ready) state_nx = S_WAIT;
            S_WAIT:     if (rsp_valid) state_nx = (issued == xfer_len) ? S_COMPLETE : S_ISSUE;
            S_COMPLETE: state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_addr    <= '0;
            xfer_len     <= '0;
            xfer_write   <= 1'b0;
            xfer_id      <= '0;
            id_ctr       <= '0;
            issued       <= '0;
            completed    <= '0;
            start_accept <= 1'b0;
            start_err    <= 1'b0;
            start_id     <= '0;
        end else begin
            start_accept <= accept;
            start_err    <= start_valid && !accept;
            if (accept) begin
                xfer_addr  <= start_addr;
                xfer_len   <= start_len;
                xfer_write <= (start_kind == KIND_STORE);
                xfer_id    <= id_ctr;
                start_id   <= id_ctr;
                id_ctr     <= id_ctr + ID_W'(1);
                issued     <= '0;
                completed  <= '0;
            end
            if (handshake) begin
                issued <= issued + LEN_W'(c_len);
            end
            if (rsp_take) begin
                completed <= issued;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (state != S_IDLE);
        req_valid     = (state == S_ISSUE);
        done_valid    = (state == S_COMPLETE);
        done_id       = xfer_id;
        req_line_addr = c_line;
        req_offset    = c_off;
        req_len       = c_len;
        req_write     = xfer_write;
    end

    dls_chunk_calc #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .MAX_LEN    (MAX_LEN)
    ) u_calc (
        .base_addr  (xfer_addr),
        .total_len  (xfer_len),
        .done_bytes (completed),
        .line_addr  (c_line),
        .line_off   (c_off),
        .chunk_len  (c_len)
    );

    dls_wr_lane #(
        .LINE_BYTES (LINE_BYTES),
        .MAX_LEN    (MAX_LEN)
    ) u_wr (
        .clk        (clk),
        .load       (accept),
        .wdata_in   (start_wdata),
        .done_bytes (completed),
        .off        (c_off),
        .clen       (c_len),
        .line_data  (req_data)
    );

    dls_rd_store #(
        .LINE_BYTES (LINE_BYTES),
        .MAX_LEN    (MAX_LEN)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (rd_we),
        .line_in    (rsp_data),
        .done_bytes (completed),
        .off        (c_off),
        .cnt        (rd_cnt),
        .buf_out    (rd_buf)
    );

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_LEN    = 256,
    parameter int ID_W       = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_accept,
    input logic                    start_err,
    input logic                    busy,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [ADDR_W-OFF_W-1:0] req_line_addr,
    input logic [OFF_W-1:0]        req_offset,
    input logic [OFF_W:0]          req_len,
    input logic                    done_valid,
    input logic [LEN_W-1:0]        completed,
    input logic [LEN_W-1:0]        xfer_len
);

    AST_ACCEPT_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_accept && start_err)); // R1

    AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_accept |-> !$past(busy)); // R1

    AST_FIRST_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0) && (int'(req_offset) + int'(req_len) <= LINE_BYTES)); // R2

    AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && completed != '0) |-> (req_offset == '0)); // R3

    AST_LATER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && completed != '0) |-> (int'(req_len) <= int'(xfer_len) - int'(completed))); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_line_addr)
                                      && $stable(req_offset) && $stable(req_len)); // R5

    AST_NO_REQ_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid); // R5

    AST_DONE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (completed == xfer_len)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid && !busy); // R6

endmodule

bind dma_line_seq dls_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .MAX_LEN    (MAX_LEN),
    .ID_W       (ID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_accept  (start_accept),
    .start_err     (start_err),
    .busy          (busy),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_line_addr (req_line_addr),
    .req_offset    (req_offset),
    .req_len       (req_len),
    .done_valid    (done_valid),
    .completed     (completed),
    .xfer_len      (xfer_len)
);

// File: tb/test_dma_line_seq.sv
`timescale 1ns/1ps
module test_dma_line_seq;
    localparam int AW = 32;
    localparam int L  = 64;
    localparam int ML = 256;
    localparam int IW = 8;
    localparam int OW = $clog2(L);
    localparam int LW = $clog2(ML + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_valid = 1'b0;
    logic [2:0]      start_kind = '0;
    logic [AW-1:0]   start_addr = '0;
    logic [LW-1:0]   start_len = '0;
    logic [ML*8-1:0] start_wdata = '0;
    logic            start_accept, start_err, busy;
    logic [IW-1:0]   start_id, done_id;
    logic            req_valid, req_write, done_valid;
    logic            req_ready = 1'b0;
    logic [AW-OW-1:0] req_line_addr;
    logic [OW-1:0]   req_offset;
    logic [OW:0]     req_len;
    logic [L*8-1:0]  req_data;
    logic            rsp_valid = 1'b0;
    logic            rsp_has_data = 1'b0;
    logic [L*8-1:0]  rsp_data = '0;
    logic [ML*8-1:0] rd_buf;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [IW-1:0] exp_id = '0;
    logic [7:0] exp_rd [ML];

    always #2.5 clk = ~clk;

    dma_line_seq i_dma_line_seq (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_kind(start_kind), .start_addr(start_addr),
        .start_len(start_len), .start_wdata(start_wdata),
        .start_accept(start_accept), .start_err(start_err), .start_id(start_id),
        .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
        .req_line_addr(req_line_addr), .req_offset(req_offset), .req_len(req_len),
        .req_write(req_write), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_has_data(rsp_has_data), .rsp_data(rsp_data),
        .done_valid(done_valid), .done_id(done_id), .rd_buf(rd_buf)
    );

    function automatic logic [7:0] mem_byte(input longint a);
        return 8'((a * 29) ^ (a >> 5) ^ 8'h3C);
    endfunction

    function automatic logic [L*8-1:0] mem_line(input longint line);
        logic [L*8-1:0] v;
        for (int i = 0; i < L; i++) v[i*8 +: 8] = mem_byte(line * L + i);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_rdbuf(input string req);
        int bad = -1;
        for (int k = 0; k < ML; k++)
            if (bad < 0 && rd_buf[k*8 +: 8] !== exp_rd[k]) bad = k;
        if (bad < 0) chk(1'b1, req, "rd_buf", 0, 0);
        else chk(1'b0, req, "rd_buf byte", rd_buf[bad*8 +: 8], exp_rd[bad]);
    endtask

    // rejected start: err next cycle, no accept, no request
    task automatic bad_start(input logic [2:0] kind, input int len, input string req);
        @(negedge clk);
        start_valid = 1'b1; start_kind = kind; start_addr = 32'h40; start_len = LW'(len);
        @(negedge clk);
        start_valid = 1'b0;
        chk(start_err === 1'b1 && start_accept === 1'b0, req, "reject", start_err, 1);
        chk(busy === 1'b0 && req_valid === 1'b0, req, "stays idle", busy, 0);
    endtask

    task automatic run_xfer(input longint addr, input int len, input bit wr,
                            input bit poke, input bit stray, input bit collide);
        logic [7:0] wb [ML];
        logic [ML*8-1:0] flat;
        int cursor, off, clen;
        logic [L*8-1:0] expd;
        for (int k = 0; k < ML; k++) begin
            wb[k] = 8'($urandom);
            flat[k*8 +: 8] = wb[k];
        end
        @(negedge clk);
        start_valid = 1'b1; start_kind = wr ? 3'd1 : 3'd0;
        start_addr = AW'(addr); start_len = LW'(len); start_wdata = flat;
        @(negedge clk);
        start_valid = 1'b0;
        chk(start_accept === 1'b1 && start_err === 1'b0, "R10", "accept", start_accept, 1);
        chk(start_id === exp_id, "R10", "start_id", start_id, exp_id);
        cursor = 0;
        while (cursor < len) begin
            while (req_valid !== 1'b1) @(negedge clk);
            off  = (cursor == 0) ? int'(addr % L) : 0;
            clen = (len - cursor < L - off) ? len - cursor : L - off;
            chk(req_offset === OW'(off), cursor == 0 ? "R2" : "R3", "offset", req_offset, off);
            chk(req_len === (OW+1)'(clen), cursor == 0 ? "R2" : "R4", "length", req_len, clen);
            chk(req_line_addr === (AW-OW)'((addr + cursor) / L), "R3", "line", req_line_addr,
                (addr + cursor) / L);
            chk(req_write === wr, "R8", "direction", req_write, wr);
            if (wr) begin
                expd = '0;
                for (int i = off; i < off + clen; i++) expd[i*8 +: 8] = wb[cursor + i - off];
                chk(req_data === expd, "R8", "store data", 0, 1);
            end
            // ready delay; optional stray response while the chunk is pending
            for (int d = $urandom_range(0, 3); d > 0; d--) begin
                if (stray && d == 1) begin rsp_valid = 1'b1; rsp_has_data = 1'b1; rsp_data = '1; end
                @(negedge clk);
                rsp_valid = 1'b0; rsp_has_data = 1'b0;
                chk(req_valid === 1'b1 && req_offset === OW'(off), "R5", "held", req_valid, 1);
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            chk(req_valid === 1'b0, "R5", "no req while waiting", req_valid, 0);
            if (poke && cursor == 0) begin
                start_valid = 1'b1; start_kind = 3'd0; start_len = 9'd4;
                @(negedge clk);
                start_valid = 1'b0;
                chk(start_err === 1'b1 && start_accept === 1'b0, "R1", "busy start", start_err, 1);
                chk(req_valid === 1'b0 && busy === 1'b1, "R1", "transfer kept", req_valid, 0);
            end
            for (int d = $urandom_range(0, 3); d > 0; d--) @(negedge clk);
            rsp_valid = 1'b1;
            rsp_has_data = !wr;
            rsp_data = wr ? L*8'($urandom) : mem_line((addr + cursor) / L);
            @(negedge clk);
            rsp_valid = 1'b0; rsp_has_data = 1'b0;
            cursor += clen;
            if (cursor < len)
                chk(done_valid === 1'b0, "R6", "early done", done_valid, 0);
        end
        chk(done_valid === 1'b1 && done_id === exp_id, "R6", "done/id", done_id, exp_id);
        if (collide) begin
            start_valid = 1'b1; start_kind = 3'd0; start_len = 9'd8;
        end
        @(negedge clk);
        start_valid = 1'b0;
        chk(busy === 1'b0 && done_valid === 1'b0, "R6", "idle after done", busy, 0);
        if (collide) chk(start_err === 1'b1 && start_accept === 1'b0, "R1", "collide", start_err, 1);
        exp_id = exp_id + 1'b1;
        if (!wr) for (int k = 0; k < len; k++) exp_rd[k] = mem_byte(addr + k);
        check_rdbuf(wr ? "R11" : "R7");
    endtask

    initial begin
        for (int k = 0; k < ML; k++) exp_rd[k] = '0;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && req_valid === 1'b0 && done_valid === 1'b0, "R12", "reset outs", busy, 0);
        chk(start_accept === 1'b0 && start_err === 1'b0, "R12", "reset strobes", start_accept, 0);
        check_rdbuf("R12");
        rst_n = 1'b1;
        @(negedge clk);

        run_xfer(0, 8, 0, 0, 0, 0);
        run_xfer(63, 1, 0, 0, 0, 0);
        run_xfer(63, 2, 1, 0, 0, 0);
        run_xfer(64, 64, 0, 0, 0, 0);
        run_xfer(5, 256, 1, 0, 0, 0);
        run_xfer(130, 200, 0, 1, 1, 1);
        run_xfer(64'h1000_0FC1, 256, 0, 0, 0, 0);
        run_xfer(32, 32, 1, 1, 1, 1);

        bad_start(3'd3, 16, "R9");
        bad_start(3'd6, 16, "R9");
        bad_start(3'd0, 0, "R9");
        bad_start(3'd1, 257, "R9");

        // response while idle must not touch the read buffer
        @(negedge clk);
        rsp_valid = 1'b1; rsp_has_data = 1'b1; rsp_data = '1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_has_data = 1'b0;
        chk(busy === 1'b0, "R11", "idle rsp", busy, 0);
        check_rdbuf("R11");

        for (int n = 0; n < 40; n++) begin
            run_xfer(longint'($urandom), $urandom_range(1, ML), 1'($urandom),
                     ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                     ($urandom_range(0, 3) == 0));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R5 actual=hung expected=progress");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule